// File: doc/BRIEF.md
# SMBus Indexed Configuration Register Target

This block is a serial-bus target that lets a host read and write a small bank of 8-bit configuration registers over a two-wire SMBus/I2C-style link. It answers at a fixed 7-bit device address. The clock and data lines arrive as plain inputs. The block drives the data line only through an open-drain enable, where a high enable pulls the wire low. The current register contents are presented in parallel on a flat output bus, which configures downstream clock logic.

Every transfer begins with a write-direction address and a command byte. Bits [3:0] of the command give the starting register index, taken modulo the 16-entry index space. In the native block mode, a write then carries a byte count followed by that many data bytes. A read uses a repeated start and the read address. The target then returns a byte count, taken from the programmable register at index 8, before it streams data. Setting command bit 7 selects plain byte mode, in which no count is sent or returned. In both modes the register pointer advances by one for every data byte.

Top module: `smb_cfg_target`

## Requirements
- R1: The target acknowledges only the address bytes 0xD2 (write) and 0xD3 (read), which are device address 0x69 with the direction bit last. After any other address byte it does not acknowledge, and it keeps SDA released until the next START.
- R2: In block mode (command bit 7 clear), the command is followed by a count X and then X data bytes. These are stored at indices N, N+1, … and each byte is acknowledged.
- R3: In a block write, data bytes beyond the count X are not acknowledged and not stored.
- R4: In a block read (write address, command N, repeated start, 0xD3), the target first returns the count register value. It then returns the registers from N upward, one per byte the host acknowledges. After the host's not-acknowledge it releases SDA.
- R5: With command bit 7 set (byte mode), no count is sent or returned. A write stores bytes at successive indices until STOP, and a read returns register N as its first byte.
- R6: The register index wraps modulo 16, so index 15 is followed by index 0.
- R7: Indices 12 to 15 are not implemented. Writes to them are acknowledged and discarded, and reads of them return 0x00.
- R8: A STOP or START in the middle of a byte aborts the transfer, and the partial byte is not stored. A new START always begins a fresh address phase.
- R9: The target changes its SDA drive only while SCL is low. The one exception is releasing SDA on a START or STOP. Its drive is stable throughout every SCL high phase.
- R10: After reset, SDA is released, the count register (index 8) holds 0x04, and all other registers hold 0x00.
- R11: The count register at index 8 is writable like any other register, and a later block read returns the written value as its count byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus (wired-AND with this block's drive) |
| sda_oe | output | 1 | Pull SDA low when 1; released when 0 |
| cfg_flat | output | 96 | Registers 0..11, register k on bits [8k+7:8k] |

## Verification
The bench builds the block with its default parameters: address 0x69, a 16-entry index space with 12 implemented registers, the count register at index 8 and two synchroniser stages. Because only 12 of the 16 indices are implemented, a single transfer that starts at index 14 crosses both the unimplemented range and the wrap back to index 0. The bench runs each bus bit over 32 system clocks. This leaves the synchroniser and edge detector enough margin to expose any acknowledge or data bit that lands in the wrong SCL phase, and the bench compares the line at both ends of every high phase.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

   localparam int BYTE_W = 8;
   localparam int BIT_CNT_W = 4;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_CMD,
      ST_WCNT,
      ST_WDATA,
      ST_RCNT,
      ST_RDATA
   } smb_st_e;

   function automatic logic st_is_tx(input smb_st_e s);
      return (s == ST_RCNT) || (s == ST_RDATA);
   endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_p,
   output logic stop_p
);

   localparam int PIPE_W = SYNC_STAGES + 1;

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("smb_line_sync: SYNC_STAGES must be at least 2");
   end

   logic [PIPE_W-1:0] scl_pipe;
   logic [PIPE_W-1:0] sda_pipe;
   logic              scl_s, scl_q, sda_q;

   // Idle bus level is high, so the pipes reset to ones.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
      end else begin
         scl_pipe <= {scl_pipe[PIPE_W-2:0], scl_i};
         sda_pipe <= {sda_pipe[PIPE_W-2:0], sda_i};
      end
   end

   assign scl_s = scl_pipe[SYNC_STAGES-1];
   assign scl_q = scl_pipe[SYNC_STAGES];
   assign sda_s = sda_pipe[SYNC_STAGES-1];
   assign sda_q = sda_pipe[SYNC_STAGES];

   assign scl_rise = scl_s & ~scl_q;
   assign scl_fall = ~scl_s & scl_q;
   assign start_p  = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_p   = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank #(
   parameter int         NUM_REGS  = 16,
   parameter int         IMPL_REGS = 12,
   parameter int         CNT_IDX   = 8,
   parameter logic [7:0] CNT_RST   = 8'h04,
   localparam int        IDXW      = $clog2(NUM_REGS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   we,
   input  logic [IDXW-1:0]        widx,
   input  logic [7:0]             wdata,
   input  logic [IDXW-1:0]        ridx,
   output logic [7:0]             rdata,
   output logic [7:0]             cnt_val,
   output logic [IMPL_REGS*8-1:0] cfg_flat
);

   if (IMPL_REGS > NUM_REGS || IMPL_REGS < 1) begin : g_bad_impl
      $error("smb_reg_bank: IMPL_REGS must be in 1..NUM_REGS");
   end
   if (CNT_IDX >= IMPL_REGS) begin : g_bad_cnt
      $error("smb_reg_bank: CNT_IDX must name an implemented register");
   end
   if ((NUM_REGS & (NUM_REGS - 1)) != 0) begin : g_bad_pow2
      $error("smb_reg_bank: NUM_REGS must be a power of two");
   end

   function automatic logic [7:0] rst_val(input int i);
      return (i == CNT_IDX) ? CNT_RST : 8'h00;
   endfunction

   logic [7:0] bank [IMPL_REGS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < IMPL_REGS; i++) bank[i] <= rst_val(i);
      end else if (we) begin
         for (int i = 0; i < IMPL_REGS; i++)
            if (widx == IDXW'(i)) bank[i] <= wdata;
      end
   end

   // Indices past the implemented range read back as zero.
   always_comb begin
      rdata = 8'h00;
      for (int i = 0; i < IMPL_REGS; i++)
         if (ridx == IDXW'(i)) rdata = bank[i];
   end

   assign cnt_val = bank[CNT_IDX];

   for (genvar g = 0; g < IMPL_REGS; g++) begin : g_flat
      assign cfg_flat[g*8 +: 8] = bank[g];
   end

endmodule

// File: rtl/smb_proto_fsm.sv
module smb_proto_fsm
   import smb_cfg_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h69,
   parameter int         IDXW     = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            scl_rise,
   input  logic            scl_fall,
   input  logic            start_p,
   input  logic            stop_p,
   input  logic            sda_s,
   input  logic [7:0]      rdata,
   input  logic [7:0]      cnt_val,
   output logic [IDXW-1:0] ridx,
   output logic            we,
   output logic [IDXW-1:0] widx,
   output logic [7:0]      wdata,
   output logic            sda_oe
);

   if (IDXW < 1 || IDXW > 7) begin : g_bad_idxw
      $error("smb_proto_fsm: index width must fit below command bit 7");
   end

   smb_st_e              st;
   logic [BIT_CNT_W-1:0] bcnt;
   logic [BYTE_W-1:0]    shreg, txreg, rem;
   logic [IDXW-1:0]      ptr;
   logic                 byte_mode, ack_own, ack_host, host_nack;

   assign ridx = ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         bcnt      <= '0;
         shreg     <= '0;
         txreg     <= '0;
         rem       <= '0;
         ptr       <= '0;
         byte_mode <= 1'b0;
         ack_own   <= 1'b0;
         ack_host  <= 1'b0;
         host_nack <= 1'b0;
         sda_oe    <= 1'b0;
         we        <= 1'b0;
         widx      <= '0;
         wdata     <= '0;
      end else begin
         we <= 1'b0;
         if (start_p || stop_p) begin
            st       <= start_p ? ST_ADDR : ST_IDLE;
            bcnt     <= '0;
            ack_own  <= 1'b0;
            ack_host <= 1'b0;
            sda_oe   <= 1'b0;
         end else if (scl_rise) begin
            if (ack_host) begin
               host_nack <= sda_s;
            end else if (!ack_own && st != ST_IDLE) begin
               bcnt <= bcnt + 1'b1;
               if (!st_is_tx(st)) shreg <= {shreg[6:0], sda_s};
            end
         end else if (scl_fall) begin
            if (ack_own) begin
               // End of the target's acknowledge slot.
               ack_own <= 1'b0;
               bcnt    <= '0;
               if (st == ST_RCNT) begin
                  txreg  <= cnt_val;
                  sda_oe <= ~cnt_val[7];
               end else if (st == ST_RDATA) begin
                  txreg  <= rdata;
                  sda_oe <= ~rdata[7];
                  ptr    <= ptr + 1'b1;
               end else begin
                  sda_oe <= 1'b0;
               end
            end else if (ack_host) begin
               // End of the host's acknowledge slot.
               ack_host <= 1'b0;
               bcnt     <= '0;
               if (host_nack) begin
                  st     <= ST_IDLE;
                  sda_oe <= 1'b0;
               end else begin
                  st     <= ST_RDATA;
                  txreg  <= rdata;
                  sda_oe <= ~rdata[7];
                  ptr    <= ptr + 1'b1;
               end
            end else if (st_is_tx(st)) begin
               if (bcnt == BIT_CNT_W'(8)) begin
                  sda_oe   <= 1'b0;
                  ack_host <= 1'b1;
               end else begin
                  sda_oe <= ~txreg[3'd7 - bcnt[2:0]];
               end
            end else if (st != ST_IDLE && bcnt == BIT_CNT_W'(8)) begin
               ack_own <= 1'b1;
               sda_oe  <= 1'b0;
               case (st)
                  ST_ADDR: begin
                     if (shreg[7:1] == DEV_ADDR) begin
                        sda_oe <= 1'b1;
                        if (!shreg[0]) st <= ST_CMD;
                        else           st <= byte_mode ? ST_RDATA : ST_RCNT;
                     end else begin
                        st      <= ST_IDLE;
                        ack_own <= 1'b0;
                     end
                  end
                  ST_CMD: begin
                     sda_oe    <= 1'b1;
                     byte_mode <= shreg[7];
                     ptr       <= shreg[IDXW-1:0];
                     st        <= shreg[7] ? ST_WDATA : ST_WCNT;
                  end
                  ST_WCNT: begin
                     sda_oe <= 1'b1;
                     rem    <= shreg;
                     st     <= ST_WDATA;
                  end
                  ST_WDATA: begin
                     if (byte_mode || rem != '0) begin
                        sda_oe <= 1'b1;
                        we     <= 1'b1;
                        widx   <= ptr;
                        wdata  <= shreg;
                        ptr    <= ptr + 1'b1;
                        if (!byte_mode) rem <= rem - 1'b1;
                     end
                  end
                  default: ack_own <= 1'b0;
               endcase
            end
         end
      end
   end

endmodule

// File: rtl/smb_cfg_target.sv
module smb_cfg_target #(
   parameter logic [6:0] DEV_ADDR    = 7'h69,
   parameter int         NUM_REGS    = 16,
   parameter int         IMPL_REGS   = 12,
   parameter int         CNT_IDX     = 8,
   parameter logic [7:0] CNT_RST     = 8'h04,
   parameter int         SYNC_STAGES = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   scl_i,
   input  logic                   sda_i,
   output logic                   sda_oe,
   output logic [IMPL_REGS*8-1:0] cfg_flat
);

   localparam int IDXW = $clog2(NUM_REGS);

   logic            sda_s, scl_rise, scl_fall, start_p, stop_p;
   logic            bank_we;
   logic [IDXW-1:0] widx, ridx;
   logic [7:0]      wdata, rdata, cnt_val;

   smb_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl_i),
      .sda_i    (sda_i),
      .sda_s    (sda_s),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_p  (start_p),
      .stop_p   (stop_p)
   );

   smb_proto_fsm #(.DEV_ADDR(DEV_ADDR), .IDXW(IDXW)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_p  (start_p),
      .stop_p   (stop_p),
      .sda_s    (sda_s),
      .rdata    (rdata),
      .cnt_val  (cnt_val),
      .ridx     (ridx),
      .we       (bank_we),
      .widx     (widx),
      .wdata    (wdata),
      .sda_oe   (sda_oe)
   );

   smb_reg_bank #(
      .NUM_REGS  (NUM_REGS),
      .IMPL_REGS (IMPL_REGS),
      .CNT_IDX   (CNT_IDX),
      .CNT_RST   (CNT_RST)
   ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (bank_we),
      .widx     (widx),
      .wdata    (wdata),
      .ridx     (ridx),
      .rdata    (rdata),
      .cnt_val  (cnt_val),
      .cfg_flat (cfg_flat)
   );

endmodule

// File: rtl/smb_cfg_target_chk.sv
module smb_cfg_target_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_i,
   input logic sda_oe,
   input logic start_p,
   input logic stop_p,
   input logic bank_we
);

   // R10
   always @(posedge clk) begin
      if (!rst_n) begin
         rst_release_chk: assert (!sda_oe);
      end
   end

   // R9
   oe_rise_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_i);

   // R9
   oe_fall_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sda_oe) |-> (!scl_i || $past(start_p || stop_p)));

   // R8
   stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_p |=> !sda_oe);

   // R8
   start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_p |=> !sda_oe);

   // R2
   write_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bank_we |-> !scl_i);

endmodule

bind smb_cfg_target smb_cfg_target_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .scl_i   (scl_i),
   .sda_oe  (sda_oe),
   .start_p (start_p),
   .stop_p  (stop_p),
   .bank_we (bank_we)
);

// File: tb/tb_smb_cfg_target.sv
module tb_smb_cfg_target;

   localparam int CLK_PERIOD = 10;
   localparam int Q          = 8;
   localparam int NREG       = 16;
   localparam int NIMPL      = 12;
   localparam int CIDX       = 8;
   localparam int NVEC       = 5;

   // {byte_mode, start index, count, seed}
   localparam logic [31:0] VEC [NVEC] = '{
      {8'h00, 8'd0,  8'd3, 8'h11},
      {8'h00, 8'd5,  8'd2, 8'hA0},
      {8'h01, 8'd2,  8'd4, 8'h31},
      {8'h00, 8'd14, 8'd4, 8'h50},
      {8'h01, 8'd10, 8'd3, 8'hC3}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_h = 1'b1;
   logic sda_h = 1'b1;
   logic sda_oe;
   logic sda_line;
   logic [NIMPL*8-1:0] cfg_flat;

   int  checks = 0;
   int  fails = 0;
   int  hi_glitch = 0;
   bit  done = 1'b0;
   logic [7:0] model [NREG];

   assign sda_line = sda_h & ~sda_oe;

   always #(CLK_PERIOD/2) clk = ~clk;

   smb_cfg_target dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl_h),
      .sda_i    (sda_line),
      .sda_oe   (sda_oe),
      .cfg_flat (cfg_flat)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic check1(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic bus_start;
      sda_h = 1'b1; tick(Q);
      scl_h = 1'b1; tick(Q);
      sda_h = 1'b0; tick(Q);
      scl_h = 1'b0; tick(Q);
   endtask

   task automatic bus_stop;
      sda_h = 1'b0; tick(Q);
      scl_h = 1'b1; tick(Q);
      sda_h = 1'b1; tick(Q);
   endtask

   task automatic put_bit(input logic b);
      sda_h = b; tick(Q);
      scl_h = 1'b1; tick(2*Q);
      scl_h = 1'b0; tick(Q);
   endtask

   task automatic get_bit(output logic b);
      sda_h = 1'b1; tick(Q);
      scl_h = 1'b1; tick(Q);
      b = sda_line; tick(Q);
      if (sda_line !== b) hi_glitch++;
      scl_h = 1'b0; tick(Q);
   endtask

   task automatic put_byte(input logic [7:0] v, output logic acked);
      logic b;
      for (int i = 7; i >= 0; i--) put_bit(v[i]);
      get_bit(b);
      acked = !b;
   endtask

   task automatic get_byte(input logic host_ack, output logic [7:0] v);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         get_bit(b);
         v[i] = b;
      end
      put_bit(!host_ack);
   endtask

   task automatic blk_write(input logic bmode, input logic [7:0] idx, input int cnt,
                            input logic [7:0] seed, input string req);
      logic a;
      logic [7:0] v;
      int j;
      bus_start;
      put_byte(8'hD2, a);                        check1({req, " R1 addr ack"}, a, 1'b1);
      put_byte(bmode ? (8'h80 | idx) : idx, a);  check1({req, " cmd ack"}, a, 1'b1);
      if (!bmode) begin
         put_byte(8'(cnt), a);                   check1({req, " count ack"}, a, 1'b1);
      end
      for (int i = 0; i < cnt; i++) begin
         v = seed + 8'(i * 29);
         put_byte(v, a);                         check1({req, " data ack"}, a, 1'b1);
         j = (int'(idx[3:0]) + i) % NREG;
         if (j < NIMPL) model[j] = v;
      end
      bus_stop;
   endtask

   task automatic blk_read(input logic bmode, input logic [7:0] idx, input int cnt,
                           input string req);
      logic a;
      logic [7:0] v, e;
      int j;
      bus_start;
      put_byte(8'hD2, a);                        check1({req, " R1 addr ack"}, a, 1'b1);
      put_byte(bmode ? (8'h80 | idx) : idx, a);  check1({req, " cmd ack"}, a, 1'b1);
      bus_start;
      put_byte(8'hD3, a);                        check1({req, " R1 read addr ack"}, a, 1'b1);
      if (!bmode) begin
         get_byte(1'b1, v);                      check8({req, " R4 count byte"}, v, model[CIDX]);
      end
      for (int i = 0; i < cnt; i++) begin
         get_byte(i != cnt - 1, v);
         j = (int'(idx[3:0]) + i) % NREG;
         e = (j < NIMPL) ? model[j] : 8'h00;
         check8({req, " read data"}, v, e);
      end
      tick(Q);
      check1({req, " R4 release after nack"}, sda_line, 1'b1);
      bus_stop;
   endtask

   initial begin
      logic a;
      string tag;
      for (int i = 0; i < NREG; i++) model[i] = 8'h00;
      model[CIDX] = 8'h04;

      tick(5);
      // R10: reset state
      check1("R10 sda released in reset", sda_line, 1'b1);
      rst_n = 1'b1;
      tick(4);
      for (int k = 0; k < NIMPL; k++)
         check8("R10 reset value", cfg_flat[k*8 +: 8], model[k]);

      // R1: foreign write and read addresses are ignored
      bus_start;
      put_byte(8'hA4, a);  check1("R1 foreign addr not acked", a, 1'b0);
      put_byte(8'h00, a);  check1("R1 sda stays released", a, 1'b0);
      bus_stop;
      bus_start;
      put_byte(8'hD5, a);  check1("R1 foreign read addr not acked", a, 1'b0);
      bus_stop;

      // Vector walk: write then read back
      for (int n = 0; n < NVEC; n++) begin
         tag = VEC[n][24] ? "R5" : "R2";
         if (int'(VEC[n][23:16]) + int'(VEC[n][15:8]) > NIMPL) tag = {tag, " R6 R7"};
         blk_write(VEC[n][24], VEC[n][23:16], int'(VEC[n][15:8]), VEC[n][7:0], tag);
         blk_read (VEC[n][24], VEC[n][23:16], int'(VEC[n][15:8]), tag);
      end

      // R3: bytes past the count are refused and dropped
      bus_start;
      put_byte(8'hD2, a);  check1("R3 addr ack", a, 1'b1);
      put_byte(8'h06, a);  check1("R3 cmd ack", a, 1'b1);
      put_byte(8'h01, a);  check1("R3 count ack", a, 1'b1);
      put_byte(8'h5A, a);  check1("R3 counted byte ack", a, 1'b1);
      put_byte(8'hA5, a);  check1("R3 extra byte not acked", a, 1'b0);
      bus_stop;
      model[6] = 8'h5A;
      tick(4);
      check8("R3 counted byte stored", cfg_flat[6*8 +: 8], 8'h5A);
      check8("R3 extra byte dropped", cfg_flat[7*8 +: 8], model[7]);

      // R11: programmable count register
      blk_write(1'b0, 8'd8, 1, 8'h02, "R11");
      tick(4);
      check8("R11 count reg on port", cfg_flat[CIDX*8 +: 8], 8'h02);
      blk_read(1'b0, 8'd0, 2, "R11");

      // R8: STOP in the middle of a data byte
      bus_start;
      put_byte(8'hD2, a);  check1("R8 addr ack", a, 1'b1);
      put_byte(8'h03, a);  check1("R8 cmd ack", a, 1'b1);
      put_byte(8'h02, a);  check1("R8 count ack", a, 1'b1);
      for (int i = 0; i < 4; i++) put_bit(1'b1);
      bus_stop;
      tick(4);
      check8("R8 partial byte not stored", cfg_flat[3*8 +: 8], model[3]);

      // R8: START in the middle of an address byte restarts the address phase
      bus_start;
      for (int i = 0; i < 3; i++) put_bit(1'b1);
      bus_start;
      put_byte(8'hD2, a);  check1("R8 addr after restart acked", a, 1'b1);
      put_byte(8'h09, a);  check1("R8 cmd ack", a, 1'b1);
      put_byte(8'h01, a);  check1("R8 count ack", a, 1'b1);
      put_byte(8'h77, a);  check1("R8 data ack", a, 1'b1);
      bus_stop;
      model[9] = 8'h77;
      tick(4);
      check8("R8 write after restart stored", cfg_flat[9*8 +: 8], 8'h77);

      // R9: target drive stable through every SCL high phase
      check1("R9 no sda change while scl high", hi_glitch == 0, 1'b1);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule